// File: doc/BRIEF.md
# NOR Flash Erase Sequencer with Suspend and Resume

This block drives a parallel NOR flash to erase either one sector or the entire array. On a start request it writes the six-cycle erase command, lets the device work for a programmable settling period, and then polls the erase address. The erase is complete once two reads in a row return the same word. Polling is bounded by a long timeout. When that timeout expires, the block writes the device reset command at the base address and reports an error.

While an erase is being polled, a host that needs to read the array can raise a suspend request. The block writes the suspend command to the block under erase and polls until the device settles. It then signals that it is suspended and leaves the bus quiet for the host. When the host drops the request, the block writes the resume command and goes back to polling with a fresh timeout. If the device does not settle after a suspend, the block resumes the erase, flags an error and carries on polling.

Top module: `nor_erase_ctrl`

## Requirements
- R1: A sector erase request writes, one word per cycle, AA to UNLOCK1, 55 to UNLOCK2, 80 to UNLOCK1, AA to UNLOCK1, 55 to UNLOCK2, then 30 to the requested sector address.
- R2: A chip erase request (req_chip=1) writes the same first five words, then 10 to UNLOCK1. UNLOCK1 is then the tracked block address.
- R3: The first poll read comes exactly SETTLE_CYC+1 cycles after the final command write. Reads then come in pairs at the block address. When a pair matches, done pulses high for one cycle, in the cycle after the matching read.
- R4: After ERASE_TMO poll pairs that do not match, the block writes F0 to BASE_ADDR. err pulses in the next cycle and done does not pulse.
- R5: If susp_req is high when a poll pair would start, the block writes B0 to the block address and polls in pairs. After a matching pair, suspended goes high. While suspended is high there are no bus writes or reads.
- R6: When susp_req falls while the block is suspended, it writes 30 to the block address in the cycle where suspended falls. Polling resumes with the erase timeout restarted, so time spent polling before the suspend does not count toward ERASE_TMO.
- R7: If SUSP_TMO suspend poll pairs pass without a match, the block writes 30 to the block address, pulses err, keeps polling the erase (with the timeout restarted), and never raises suspended. A new suspend is not attempted until susp_req has been low.
- R8: susp_req has no effect while no erase is in progress: no bus activity and suspended stays low.
- R9: A start request while an erase is in progress is ignored and produces no bus writes.
- R10: done and err are single-cycle pulses and never high together. fl_we and fl_rd are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start pulse for an erase |
| req_chip | input | 1 | 1 selects a whole-array erase |
| req_addr | input | AW | Sector address for a sector erase |
| susp_req | input | 1 | Level request to suspend the running erase |
| done | output | 1 | Erase completed pulse |
| err | output | 1 | Erase timeout or suspend failure pulse |
| suspended | output | 1 | Erase is suspended and the bus is free |
| fl_addr | output | AW | Flash address |
| fl_wdata | output | DW | Flash write data |
| fl_we | output | 1 | Flash write strobe, one word per cycle |
| fl_rd | output | 1 | Flash read strobe |
| fl_rdata | input | DW | Flash read data, valid in the cycle fl_rd is high |

## Verification
The assertions assume that fl_rdata is valid in the same cycle as fl_rd. They also assume the device accepts one command word per cycle, so all written words are command codes and F0, 30 and B0 appear only where the sequencer puts them. The bench flash model answers reads combinationally. It toggles one data bit on every read while an erase is running, and it counts erase time only while not suspended. Stimulus changes susp_req and req_valid only on the falling edge. Erase lengths are chosen so that each scenario, including the restarted timeout, lands clearly on one side of the ERASE_TMO and SUSP_TMO limits.

// File: rtl/nor_erase_pkg.sv
package nor_erase_pkg;

    localparam int NSTEPS = 6;

    localparam logic [7:0] C_UNLK_A  = 8'hAA;
    localparam logic [7:0] C_UNLK_B  = 8'h55;
    localparam logic [7:0] C_SETUP   = 8'h80;
    localparam logic [7:0] C_SECTOR  = 8'h30;
    localparam logic [7:0] C_ALL     = 8'h10;
    localparam logic [7:0] C_SUSPEND = 8'hB0;
    localparam logic [7:0] C_RESUME  = 8'h30;
    localparam logic [7:0] C_RESET   = 8'hF0;

    typedef enum logic [3:0] {
        ST_IDLE, ST_CMD, ST_SETTLE, ST_PA, ST_PB, ST_KILL,
        ST_SCMD, ST_SA, ST_SB, ST_SUSP, ST_RESUME, ST_SFAIL
    } state_e;

    typedef enum logic [1:0] { SEL_U1, SEL_U2, SEL_BLK } sel_e;

    typedef struct packed {
        sel_e       sel;
        logic [7:0] code;
    } step_t;

    function automatic step_t seq_step(input logic [2:0] i, input logic chip);
        step_t s;
        case (i)
            3'd0:    s = '{SEL_U1, C_UNLK_A};
            3'd1:    s = '{SEL_U2, C_UNLK_B};
            3'd2:    s = '{SEL_U1, C_SETUP};
            3'd3:    s = '{SEL_U1, C_UNLK_A};
            3'd4:    s = '{SEL_U2, C_UNLK_B};
            default: s = chip ? step_t'{SEL_U1, C_ALL} : step_t'{SEL_BLK, C_SECTOR};
        endcase
        return s;
    endfunction

endpackage

// File: rtl/nor_erase_cmd_rom.sv
module nor_erase_cmd_rom
    import nor_erase_pkg::*;
#(
    parameter int          AW      = 12,
    parameter int          DW      = 8,
    parameter logic [AW-1:0] UNLOCK1 = 'h555,
    parameter logic [AW-1:0] UNLOCK2 = 'h2AA
) (
    input  logic [2:0]    step,
    input  logic          chip,
    input  logic [AW-1:0] blk,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] data
);
    step_t s;

    always_comb begin
        s    = seq_step(step, chip);
        data = DW'(s.code);
        case (s.sel)
            SEL_U1:  addr = UNLOCK1;
            SEL_U2:  addr = UNLOCK2;
            default: addr = blk;
        endcase
    end
endmodule

// File: rtl/nor_erase_timer.sv
module nor_erase_timer #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic last
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr)   cnt_q <= '0;
        else if (inc)     cnt_q <= cnt_q + 1'b1;
    end

    assign last = (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/nor_erase_ctrl.sv
module nor_erase_ctrl
    import nor_erase_pkg::*;
#(
    parameter int            AW         = 12,
    parameter int            DW         = 8,
    parameter logic [AW-1:0] UNLOCK1    = 'h555,
    parameter logic [AW-1:0] UNLOCK2    = 'h2AA,
    parameter logic [AW-1:0] BASE_ADDR  = '0,
    parameter int            SETTLE_CYC = 64,
    parameter int            ERASE_TMO  = 4096,
    parameter int            SUSP_TMO   = 64
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic          req_chip,
    input  logic [AW-1:0] req_addr,
    input  logic          susp_req,
    output logic          done,
    output logic          err,
    output logic          suspended,
    output logic [AW-1:0] fl_addr,
    output logic [DW-1:0] fl_wdata,
    output logic          fl_we,
    output logic          fl_rd,
    input  logic [DW-1:0] fl_rdata
);
    localparam logic [2:0] LAST_STEP = 3'(NSTEPS - 1);

    state_e        state_q;
    logic [2:0]    idx_q;
    logic          chip_q;
    logic [AW-1:0] blk_q;
    logic [DW-1:0] first_q;
    logic          done_q, err_q, sblk_q;

    logic [AW-1:0] rom_addr;
    logic [DW-1:0] rom_data;
    logic          settle_last, etmo_last, stmo_last;
    logic          match;

    assign match = (fl_rdata == first_q);

    nor_erase_cmd_rom #(.AW(AW), .DW(DW), .UNLOCK1(UNLOCK1), .UNLOCK2(UNLOCK2)) u_rom (
        .step(idx_q), .chip(chip_q), .blk(blk_q), .addr(rom_addr), .data(rom_data)
    );

    nor_erase_timer #(.LIMIT(SETTLE_CYC)) u_settle (
        .clk(clk), .rst(rst),
        .clr(state_q != ST_SETTLE),
        .inc(state_q == ST_SETTLE),
        .last(settle_last)
    );

    nor_erase_timer #(.LIMIT(ERASE_TMO)) u_etmo (
        .clk(clk), .rst(rst),
        .clr(state_q == ST_IDLE || state_q == ST_RESUME || state_q == ST_SFAIL),
        .inc(state_q == ST_PB && !match && !etmo_last),
        .last(etmo_last)
    );

    nor_erase_timer #(.LIMIT(SUSP_TMO)) u_stmo (
        .clk(clk), .rst(rst),
        .clr(state_q == ST_SCMD),
        .inc(state_q == ST_SB && !match && !stmo_last),
        .last(stmo_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            chip_q  <= 1'b0;
            blk_q   <= '0;
            first_q <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
            sblk_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            if (!susp_req) sblk_q <= 1'b0;
            case (state_q)
                ST_IDLE: if (req_valid) begin
                    chip_q  <= req_chip;
                    blk_q   <= req_chip ? UNLOCK1 : req_addr;
                    idx_q   <= '0;
                    state_q <= ST_CMD;
                end
                ST_CMD: begin
                    if (idx_q == LAST_STEP) state_q <= ST_SETTLE;
                    else                    idx_q   <= idx_q + 1'b1;
                end
                ST_SETTLE: if (settle_last) state_q <= ST_PA;
                ST_PA: begin
                    if (susp_req && !sblk_q) state_q <= ST_SCMD;
                    else begin
                        first_q <= fl_rdata;
                        state_q <= ST_PB;
                    end
                end
                ST_PB: begin
                    if (match) begin
                        done_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end else if (etmo_last) state_q <= ST_KILL;
                    else                    state_q <= ST_PA;
                end
                ST_KILL: begin
                    err_q   <= 1'b1;
                    state_q <= ST_IDLE;
                end
                ST_SCMD: state_q <= ST_SA;
                ST_SA: begin
                    first_q <= fl_rdata;
                    state_q <= ST_SB;
                end
                ST_SB: begin
                    if (match)          state_q <= ST_SUSP;
                    else if (stmo_last) state_q <= ST_SFAIL;
                    else                state_q <= ST_SA;
                end
                ST_SUSP:   if (!susp_req) state_q <= ST_RESUME;
                ST_RESUME: state_q <= ST_PA;
                ST_SFAIL: begin
                    err_q   <= 1'b1;
                    sblk_q  <= 1'b1;
                    state_q <= ST_PA;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        fl_we    = 1'b0;
        fl_rd    = 1'b0;
        fl_addr  = blk_q;
        fl_wdata = '0;
        case (state_q)
            ST_CMD: begin
                fl_we    = 1'b1;
                fl_addr  = rom_addr;
                fl_wdata = rom_data;
            end
            ST_PA:  fl_rd = !(susp_req && !sblk_q);
            ST_PB, ST_SA, ST_SB: fl_rd = 1'b1;
            ST_KILL: begin
                fl_we    = 1'b1;
                fl_addr  = BASE_ADDR;
                fl_wdata = DW'(C_RESET);
            end
            ST_SCMD: begin
                fl_we    = 1'b1;
                fl_wdata = DW'(C_SUSPEND);
            end
            ST_RESUME, ST_SFAIL: begin
                fl_we    = 1'b1;
                fl_wdata = DW'(C_RESUME);
            end
            default: ;
        endcase
    end

    assign done      = done_q;
    assign err       = err_q;
    assign suspended = (state_q == ST_SUSP);
endmodule

// File: rtl/nor_erase_chk.sv
module nor_erase_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          done,
    input logic          err,
    input logic          suspended,
    input logic          fl_we,
    input logic          fl_rd,
    input logic [DW-1:0] fl_wdata
);
    p_bus_excl_r10: assert property (@(posedge clk) disable iff (rst)
        !(fl_we && fl_rd));

    p_status_excl_r10: assert property (@(posedge clk) disable iff (rst)
        !(done && err));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_after_read_r3: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(fl_rd));

    p_kill_then_err_r4: assert property (@(posedge clk) disable iff (rst)
        (fl_we && fl_wdata == DW'(8'hF0)) |=> (err && !done));

    p_quiet_susp_r5: assert property (@(posedge clk) disable iff (rst)
        suspended |-> (!fl_we && !fl_rd));

    p_susp_after_read_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(suspended) |-> $past(fl_rd));

    p_resume_cmd_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(suspended) |-> (fl_we && fl_wdata == DW'(8'h30)));
endmodule

bind nor_erase_ctrl nor_erase_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst(rst), .done(done), .err(err), .suspended(suspended),
    .fl_we(fl_we), .fl_rd(fl_rd), .fl_wdata(fl_wdata)
);

// File: tb/test_nor_erase_ctrl.sv
`timescale 1ns/1ps
module test_nor_erase_ctrl;
    localparam int AW = 12;
    localparam int DW = 8;
    localparam logic [AW-1:0] U1 = 12'h555;
    localparam logic [AW-1:0] U2 = 12'h2AA;
    localparam int SETTLE = 8;
    localparam int ETMO   = 40;
    localparam int STMO   = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0, req_chip = 1'b0, susp_req = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic done, err, suspended, fl_we, fl_rd;
    logic [AW-1:0] fl_addr;
    logic [DW-1:0] fl_wdata, fl_rdata;

    always #2.5 clk = ~clk;

    nor_erase_ctrl #(.AW(AW), .DW(DW), .UNLOCK1(U1), .UNLOCK2(U2), .BASE_ADDR('0),
        .SETTLE_CYC(SETTLE), .ERASE_TMO(ETMO), .SUSP_TMO(STMO)) i_nor_erase_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_chip(req_chip),
        .req_addr(req_addr), .susp_req(susp_req), .done(done), .err(err),
        .suspended(suspended), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
        .fl_we(fl_we), .fl_rd(fl_rd), .fl_rdata(fl_rdata)
    );

    // flash model: bit 6 toggles on each read while erasing
    int   m_load = 40;
    bit   m_ignore = 1'b0;
    logic m_erasing, m_susp, m_tog;
    int   m_busy, m_lat;

    assign fl_rdata = (m_erasing && (!m_susp || m_lat != 0)) ? {1'b0, m_tog, 6'h3F} : 8'hFF;

    always @(posedge clk) begin
        if (rst) begin
            m_erasing <= 1'b0; m_susp <= 1'b0; m_tog <= 1'b0; m_busy <= 0; m_lat <= 0;
        end else begin
            if (fl_rd) m_tog <= ~m_tog;
            if (m_lat != 0) m_lat <= m_lat - 1;
            if (m_erasing && !m_susp) begin
                if (m_busy == 0) m_erasing <= 1'b0;
                else             m_busy <= m_busy - 1;
            end
            if (fl_we) begin
                case (fl_wdata)
                    8'h10, 8'h30: begin
                        if (!m_erasing) begin m_erasing <= 1'b1; m_busy <= m_load; end
                        else if (m_susp) m_susp <= 1'b0;
                    end
                    8'hB0: if (m_erasing && !m_ignore) begin m_susp <= 1'b1; m_lat <= 4; end
                    8'hF0: begin m_erasing <= 1'b0; m_susp <= 1'b0; end
                    default: ;
                endcase
            end
        end
    end

    int checks = 0, fails = 0, cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // scoreboard of expected bus writes
    logic [AW-1:0] q_addr[$];
    logic [DW-1:0] q_data[$];
    string         q_req[$];
    bit            q_fin[$];
    bit arm = 1'b0;
    int fin_cyc = 0;

    task automatic push(input logic [AW-1:0] a, input logic [DW-1:0] d, input string r, input bit f);
        q_addr.push_back(a); q_data.push_back(d); q_req.push_back(r); q_fin.push_back(f);
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (fl_we) begin
                if (q_addr.size() == 0) chk(1'b0, "R9 unexpected write", {fl_addr, fl_wdata}, 0);
                else begin
                    logic [AW-1:0] ea;
                    logic [DW-1:0] ed;
                    string er;
                    bit ef;
                    ea = q_addr.pop_front(); ed = q_data.pop_front();
                    er = q_req.pop_front();  ef = q_fin.pop_front();
                    chk(fl_addr == ea && fl_wdata == ed, er, {fl_addr, fl_wdata}, {ea, ed});
                    if (ef) begin arm = 1'b1; fin_cyc = cyc; end
                end
            end
            if (fl_rd && arm) begin
                arm = 1'b0;
                chk(cyc - fin_cyc == SETTLE + 1, "R3 settle gap", cyc - fin_cyc, SETTLE + 1);
            end
            if (done && err) chk(1'b0, "R10 done with err", 1, 0);
        end
    end

    task automatic start_erase(input bit chip, input logic [AW-1:0] a, input string r);
        logic [AW-1:0] blk;
        blk = chip ? U1 : a;
        push(U1, 8'hAA, r, 0); push(U2, 8'h55, r, 0); push(U1, 8'h80, r, 0);
        push(U1, 8'hAA, r, 0); push(U2, 8'h55, r, 0);
        push(blk, chip ? 8'h10 : 8'h30, r, 1);
        @(negedge clk);
        req_valid = 1'b1; req_chip = chip; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_status(input int maxc, output bit d, output bit e);
        d = 0; e = 0;
        for (int i = 0; i < maxc; i++) begin
            @(negedge clk);
            if (done || err) begin d = done; e = err; break; end
        end
    endtask

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    bit wd_hit = 1'b0;
    initial begin
        repeat (150000) @(posedge clk);
        wd_hit = 1'b1;
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        bit d, e;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!done && !err && !suspended && !fl_we && !fl_rd, "reset state",
            {done, err, suspended, fl_we, fl_rd}, 0);

        // R8: suspend request while idle has no effect
        susp_req = 1'b1;
        begin
            bit quiet;
            quiet = 1'b1;
            for (int i = 0; i < 10; i++) begin
                @(negedge clk);
                if (fl_we || fl_rd || suspended) quiet = 1'b0;
            end
            chk(quiet, "R8 idle suspend ignored", quiet, 1);
        end
        susp_req = 1'b0;

        // R1 + R9: sector erase with a stray request while busy
        m_load = 40; m_ignore = 1'b0;
        start_erase(1'b0, 12'h123, "R1 sector sequence");
        idle_cycles(20);
        req_valid = 1'b1; req_chip = 1'b1; req_addr = 12'h0AB;
        @(negedge clk);
        req_valid = 1'b0;
        wait_status(300, d, e);
        chk(d && !e, "R3 sector erase done", {d, e}, 2'b10);
        @(negedge clk);
        chk(!done, "R10 done single pulse", done, 0);
        chk(q_addr.size() == 0, "R9 busy request ignored", q_addr.size(), 0);

        // R2: chip erase
        m_load = 30;
        start_erase(1'b1, 12'h000, "R2 chip sequence");
        wait_status(300, d, e);
        chk(d && !e, "R2 chip erase done", {d, e}, 2'b10);

        // R5 + R6: suspend, hold, resume, restarted timeout
        m_load = 130;
        start_erase(1'b0, 12'h456, "R1 sector sequence");
        push(12'h456, 8'hB0, "R5 suspend command", 0);
        push(12'h456, 8'h30, "R6 resume command", 0);
        idle_cycles(73);
        susp_req = 1'b1;
        for (int i = 0; i < 100 && !suspended; i++) @(negedge clk);
        chk(suspended, "R5 suspended raised", suspended, 1);
        begin
            bit quiet;
            quiet = 1'b1;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                if (fl_rd || fl_we || !suspended) quiet = 1'b0;
            end
            chk(quiet, "R5 bus quiet while suspended", quiet, 1);
        end
        susp_req = 1'b0;
        @(negedge clk);
        chk(!suspended, "R6 suspended falls on resume", suspended, 0);
        wait_status(400, d, e);
        chk(d && !e, "R6 timeout restarted after resume", {d, e}, 2'b10);

        // R7: suspend never settles
        m_load = 90; m_ignore = 1'b1;
        start_erase(1'b0, 12'h789, "R1 sector sequence");
        push(12'h789, 8'hB0, "R7 suspend command", 0);
        push(12'h789, 8'h30, "R7 resume after failed suspend", 0);
        idle_cycles(28);
        susp_req = 1'b1;
        wait_status(200, d, e);
        chk(e && !d, "R7 suspend failure error", {d, e}, 2'b01);
        chk(!suspended, "R7 suspended stays low", suspended, 0);
        idle_cycles(10);
        susp_req = 1'b0;
        wait_status(300, d, e);
        chk(d && !e, "R7 erase continues to done", {d, e}, 2'b10);
        m_ignore = 1'b0;

        // R4: erase never completes
        m_load = 100000;
        start_erase(1'b0, 12'h0F0, "R1 sector sequence");
        push(12'h000, 8'hF0, "R4 reset command", 0);
        wait_status(300, d, e);
        chk(e && !d, "R4 erase timeout error", {d, e}, 2'b01);
        @(negedge clk);
        chk(!err && !done, "R10 err single pulse", {done, err}, 0);
        idle_cycles(10);
        chk(q_addr.size() == 0, "R9 all expected writes seen", q_addr.size(), 0);

        if (!wd_hit) begin
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule